// File: doc/BRIEF.md
# Two-Buffer Video Burst Command Sequencer

This block decides which burst command a memory controller port executes next, for a memory that holds two video frame buffers. Two video sources each have a write FIFO. Each FIFO reports its fill level. When a FIFO holds at least one full write burst, that source asks for a write. One display stream drains a read FIFO, which reports its free space. When there is room for a full read burst, the stream asks for a read. A select input names the buffer the display should show.

For every port the block keeps a burst index. Each index wraps at the end of one 640x480 frame of 2-byte pixels. The index is scaled to a 30-bit byte address, and the second buffer sits at a fixed base offset. The block picks one requesting port in round-robin order. It holds off while the controller is not ready, and it emits a one-cycle command strobe together with the port code, the burst length and the byte address.

The select input is sampled only when a frame's first read burst is issued, so one displayed frame never mixes the two buffers.

Top module: `fb_cmd_seq`

## Requirements
- R1: While reset is held, and after it until a port requests, `cmd_valid` stays low. The first command of each port uses burst index 0.
- R2: A write for source 0 (port code 0) is issued only when `src0_level` is at least 32. Its length is 32 words and its address is index×128, where the index advances by one per source-0 write.
- R3: A write for source 1 (port code 1) is issued only when `src1_level` is at least 32. Its length is 32 and its address is 0x100000 + index×128.
- R4: A read (port code 2) is issued only when `rd_space` is at least 16. Its length is 16 and its address is base + index×64, where base is 0 for buffer 0 and 0x100000 for buffer 1.
- R5: The read index runs from 0 to 9599. The read after index 9599 uses index 0, so the last read of a frame has offset 614336.
- R6: Each write index runs from 0 to 4799 and then returns to 0. The last write offset of a frame is 614272.
- R7: The buffer for a frame's reads is the value of `buf_sel` at the clock edge that issues that frame's index-0 read. A change of `buf_sel` in mid-frame does not alter that frame's reads.
- R8: When several ports request at once, grants rotate in the order 0, 1, 2, 0, and each time the search starts at the port after the last one granted.
- R9: No command is issued while `cmd_ready` is low. `cmd_valid` is a single-cycle strobe, and it is followed by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_sel | input | 1 | Buffer requested for display (0 or 1) |
| src0_level | input | 8 | Words held in source 0 write FIFO |
| src1_level | input | 8 | Words held in source 1 write FIFO |
| rd_space | input | 8 | Free words in the read FIFO |
| cmd_ready | input | 1 | Controller can accept a command |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_port | output | 2 | 0 = source 0 write, 1 = source 1 write, 2 = read |
| cmd_len | output | 6 | Burst length in 32-bit words |
| cmd_addr | output | 30 | Byte address of the burst |

## Verification
The in-line assertions check on every cycle the following rules:
- A command follows a ready cycle.
- A command goes only to a port whose FIFO qualified it in the cycle before.
- Every strobe is followed by an idle cycle.
- The read index stays inside a frame.
- The displayed buffer is held between frame starts.

Only the bench's scenarios can show the following:
- The exact address sequence, including both wrap points.
- The rotation of grants among competing ports.
- The rule that a mid-frame `buf_sel` change appears only on the following frame.

For these, the bench runs full frames of reads and writes against its own index model.

// File: rtl/fb_cmd_seq.sv
module fb_cmd_seq #(
  parameter int H_PIX     = 640,
  parameter int V_PIX     = 480,
  parameter int PIX_BYTES = 2,
  parameter int WORD_BYTES = 4,
  parameter int RD_BURST  = 16,
  parameter int WR_BURST  = 32,
  parameter int ADDR_W    = 30,
  parameter int LVL_W     = 8,
  parameter int BUF1_BASE = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_sel,
  input  logic [LVL_W-1:0]  src0_level,
  input  logic [LVL_W-1:0]  src1_level,
  input  logic [LVL_W-1:0]  rd_space,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [1:0]        cmd_port,
  output logic [$clog2((RD_BURST > WR_BURST ? RD_BURST : WR_BURST) + 1)-1:0] cmd_len,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int FRAME_BYTES = H_PIX * V_PIX * PIX_BYTES;
  localparam int RD_BYTES    = RD_BURST * WORD_BYTES;
  localparam int WR_BYTES    = WR_BURST * WORD_BYTES;
  localparam int RD_LAST     = FRAME_BYTES / RD_BYTES - 1;
  localparam int WR_LAST     = FRAME_BYTES / WR_BYTES - 1;
  localparam int RD_IW       = $clog2(RD_LAST + 1);
  localparam int WR_IW       = $clog2(WR_LAST + 1);
  localparam int LEN_W       = $clog2((RD_BURST > WR_BURST ? RD_BURST : WR_BURST) + 1);
  localparam logic [1:0] P_W0 = 2'd0, P_W1 = 2'd1, P_RD = 2'd2;

  logic [WR_IW-1:0] w0_idx, w1_idx;
  logic [RD_IW-1:0] rd_idx;
  logic             rd_buf;
  logic [1:0]       last;
  logic [2:0]       req;
  logic [1:0]       pick;
  logic             hit, go, use_buf;
  logic [ADDR_W-1:0] nxt_addr;

  assign req[0] = src0_level >= LVL_W'(WR_BURST);
  assign req[1] = src1_level >= LVL_W'(WR_BURST);
  assign req[2] = rd_space   >= LVL_W'(RD_BURST);

  always_comb begin
    pick = last;
    hit  = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      int c;
      c = (int'(last) + k) % 3;
      if (!hit && req[c]) begin
        hit  = 1'b1;
        pick = 2'(c);
      end
    end
  end

  assign go      = hit && cmd_ready && !cmd_valid;
  assign use_buf = (rd_idx == '0) ? buf_sel : rd_buf;

  always_comb begin
    case (pick)
      P_W0:    nxt_addr = ADDR_W'(w0_idx) * ADDR_W'(WR_BYTES);
      P_W1:    nxt_addr = ADDR_W'(BUF1_BASE) + ADDR_W'(w1_idx) * ADDR_W'(WR_BYTES);
      default: nxt_addr = (use_buf ? ADDR_W'(BUF1_BASE) : '0) + ADDR_W'(rd_idx) * ADDR_W'(RD_BYTES);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_port  <= P_W0;
      cmd_len   <= '0;
      cmd_addr  <= '0;
      w0_idx    <= '0;
      w1_idx    <= '0;
      rd_idx    <= '0;
      rd_buf    <= 1'b0;
      last      <= P_RD;
    end else begin
      cmd_valid <= go;
      if (go) begin
        cmd_port <= pick;
        cmd_addr <= nxt_addr;
        cmd_len  <= (pick == P_RD) ? LEN_W'(RD_BURST) : LEN_W'(WR_BURST);
        last     <= pick;
        case (pick)
          P_W0: w0_idx <= (w0_idx == WR_IW'(WR_LAST)) ? '0 : w0_idx + 1'b1;
          P_W1: w1_idx <= (w1_idx == WR_IW'(WR_LAST)) ? '0 : w1_idx + 1'b1;
          default: begin
            rd_buf <= use_buf;
            rd_idx <= (rd_idx == RD_IW'(RD_LAST)) ? '0 : rd_idx + 1'b1;
          end
        endcase
      end
    end
  end

  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cmd_ready)); // R9
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R9
  AST_SRC0_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_port == P_W0) |-> ($past(src0_level) >= LVL_W'(WR_BURST))); // R2
  AST_SRC1_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_port == P_W1) |-> ($past(src1_level) >= LVL_W'(WR_BURST))); // R3
  AST_RD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_port == P_RD) |-> ($past(rd_space) >= LVL_W'(RD_BURST))); // R4
  AST_RD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx <= RD_IW'(RD_LAST)); // R5
  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (w0_idx <= WR_IW'(WR_LAST)) && (w1_idx <= WR_IW'(WR_LAST))); // R6
  AST_FRAME_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != '0 && $past(rd_idx) != '0) |-> $stable(rd_buf)); // R7
endmodule

// File: tb/fb_cmd_seq_bench.sv
module fb_cmd_seq_bench;
  localparam int RD_LAST = 9599;
  localparam int WR_LAST = 4799;
  localparam int BASE1   = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_sel = 1'b0;
  logic [7:0] src0_level = '0, src1_level = '0, rd_space = '0;
  logic cmd_ready = 1'b1;
  logic cmd_valid;
  logic [1:0] cmd_port;
  logic [5:0] cmd_len;
  logic [29:0] cmd_addr;

  fb_cmd_seq u_fb_cmd_seq (
    .clk(clk), .rst_n(rst_n), .buf_sel(buf_sel),
    .src0_level(src0_level), .src1_level(src1_level), .rd_space(rd_space),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_port(cmd_port),
    .cmd_len(cmd_len), .cmd_addr(cmd_addr)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, ncmd = 0;
  int e_w0 = 0, e_w1 = 0, e_r = 0, frame_buf = 0;
  int last_port = 0, last_addr = 0;
  bit prev_v = 1'b0, sel_q = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) sel_q <= buf_sel;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      int ea;
      ncmd++;
      last_port = int'(cmd_port);
      last_addr = int'(cmd_addr);
      chk(!prev_v, "R9 gap", 1, 0);
      case (cmd_port)
        2'd0: begin
          ea = e_w0 * 128;
          chk(int'(cmd_addr) == ea, "R2 src0 addr", int'(cmd_addr), ea);
          chk(cmd_len == 6'd32, "R2 src0 len", int'(cmd_len), 32);
          e_w0 = (e_w0 == WR_LAST) ? 0 : e_w0 + 1;
        end
        2'd1: begin
          ea = BASE1 + e_w1 * 128;
          chk(int'(cmd_addr) == ea, "R3 src1 addr", int'(cmd_addr), ea);
          chk(cmd_len == 6'd32, "R3 src1 len", int'(cmd_len), 32);
          e_w1 = (e_w1 == WR_LAST) ? 0 : e_w1 + 1;
        end
        default: begin
          if (e_r == 0) frame_buf = int'(sel_q);
          ea = frame_buf * BASE1 + e_r * 64;
          chk(int'(cmd_addr) == ea, "R4 read addr", int'(cmd_addr), ea);
          chk(cmd_len == 6'd16, "R4 read len", int'(cmd_len), 16);
          e_r = (e_r == RD_LAST) ? 0 : e_r + 1;
        end
      endcase
    end
    prev_v = cmd_valid;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_check(input int n, input string tag);
    int c0 = ncmd;
    for (int i = 0; i < n; i++) tick();
    chk(ncmd == c0, tag, ncmd - c0, 0);
  endtask

  task automatic wait_cmd(input string tag);
    int c0 = ncmd;
    for (int i = 0; i < 50 && ncmd == c0; i++) tick();
    chk(ncmd != c0, tag, ncmd - c0, 1);
  endtask

  task automatic quiet();
    src0_level = '0; src1_level = '0; rd_space = '0;
    tick(); tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(cmd_valid == 1'b0, "R1 in reset", int'(cmd_valid), 0);
    end
    src0_level = 8'd200; src1_level = 8'd200; rd_space = 8'd200;
    tick(); tick();
    chk(ncmd == 0, "R1 reset holds commands", ncmd, 0);
    rst_n = 1'b1;
    src0_level = '0; src1_level = '0; rd_space = '0;
    idle_check(8, "R1 idle after reset");
  endtask

  task automatic t_src0();
    src0_level = 8'd31;
    idle_check(10, "R2 below threshold");
    src0_level = 8'd32;
    wait_cmd("R2 write issued");
    chk(last_port == 0 && last_addr == 0, "R2 first addr", last_addr, 0);
    wait_cmd("R2 second write");
    chk(last_addr == 128, "R2 second addr", last_addr, 128);
    quiet();
  endtask

  task automatic t_src1();
    src1_level = 8'd31;
    idle_check(10, "R3 below threshold");
    src1_level = 8'd40;
    wait_cmd("R3 write issued");
    chk(last_port == 1 && last_addr == BASE1, "R3 first addr", last_addr, BASE1);
    wait_cmd("R3 second write");
    chk(last_addr == BASE1 + 128, "R3 second addr", last_addr, BASE1 + 128);
    quiet();
  endtask

  task automatic t_read();
    rd_space = 8'd15;
    idle_check(10, "R4 no room");
    rd_space = 8'd16;
    wait_cmd("R4 read issued");
    chk(last_port == 2 && last_addr == 0, "R4 first read", last_addr, 0);
    quiet();
  endtask

  task automatic t_ready();
    cmd_ready = 1'b0;
    src0_level = 8'd32; src1_level = 8'd32; rd_space = 8'd16;
    idle_check(12, "R9 ready low");
    cmd_ready = 1'b1;
    wait_cmd("R9 resumes");
    quiet();
  endtask

  task automatic t_rr();
    int prev;
    src0_level = 8'd64; src1_level = 8'd64; rd_space = 8'd64;
    wait_cmd("R8 first grant");
    prev = last_port;
    for (int i = 0; i < 6; i++) begin
      wait_cmd("R8 grant");
      chk(last_port == (prev + 1) % 3, "R8 rotation", last_port, (prev + 1) % 3);
      prev = last_port;
    end
    quiet();
  endtask

  task automatic t_rd_wrap();
    int guard = 0;
    rd_space = 8'd16;
    buf_sel = 1'b0;
    while (e_r != 0 && guard < 40000) begin tick(); guard++; end
    wait_cmd("R7 frame start");
    chk(last_addr == 0, "R7 frame on buffer 0", last_addr, 0);
    while (e_r != 5000 && guard < 40000) begin tick(); guard++; end
    buf_sel = 1'b1;
    wait_cmd("R7 mid-frame read");
    chk(last_addr == 5000 * 64, "R7 select ignored mid-frame", last_addr, 5000 * 64);
    while (e_r != 0 && guard < 40000) begin tick(); guard++; end
    chk(last_addr == RD_LAST * 64, "R5 last read offset", last_addr, RD_LAST * 64);
    wait_cmd("R5 wrapped read");
    chk(last_addr == BASE1, "R5 R7 wrap to buffer 1", last_addr, BASE1);
    quiet();
    buf_sel = 1'b0;
  endtask

  task automatic t_wr_wrap();
    int guard = 0;
    src0_level = 8'd32;
    while (e_w0 != 0 && guard < 20000) begin tick(); guard++; end
    chk(last_addr == WR_LAST * 128, "R6 last write offset", last_addr, WR_LAST * 128);
    wait_cmd("R6 wrapped write");
    chk(last_addr == 0, "R6 wrap to zero", last_addr, 0);
    quiet();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_src0();
    t_src1();
    t_read();
    t_ready();
    t_rr();
    t_rd_wrap();
    t_wr_wrap();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule